// File: doc/BRIEF.md
# VT V5 Overhead Byte Generator

This block produces the V5 path overhead byte of one virtual tributary. It sits in a byte-wide transmit stream. The stream carries tags that mark the pointer bytes and the slot where V5 belongs. Every byte other than V5 passes through unchanged. At each V5 slot the block writes a freshly built byte. That byte carries:

- a two-bit interleaved parity (BIP-2) over the previous superframe;
- a signal label derived from a 4-bit mapping type;
- the remote indication bits, which come either from the stored received V5 or are cleared.

The block has three overriding conditions: tributary loopback, which copies the received V5 verbatim; UPSR regeneration, which rebuilds only the parity and the label; and AIS-V, which turns every byte of the tributary, pointer bytes included, into all ones. A two-bit error-injection mode can corrupt the parity field on every V5 or once per strobe. This lets downstream error monitors be exercised.

A two-state controller tracks whether a full superframe has been seen since reset. In state S_SEEK no complete parity window exists yet. The transition T_FIRST_V5 fires on the first valid V5 slot and moves the controller to S_RUN, where it stays until reset. The transition T_HOLD is the self-loop in each state.

Top module: `v5_overhead_gen`

## Requirements
- R1: Output `out_vld` and `out_byte` follow `in_vld` and the selected byte after exactly one clock edge. During and after reset, `out_vld` is 0 and `out_byte` is 0x00.
- R2: With `ais_en` low, every valid byte not tagged `in_v5` leaves unchanged, pointer bytes included.
- R3: With `ais_en` high, every valid output byte is 0xFF. This holds for V5, pointer and payload bytes, and overrides every other mode and error setting.
- R4: With `lb_en` high and `ais_en` low, the V5 slot outputs `rx_v5` unchanged, and no error injection applies.
- R5: Byte bits are numbered 1 (MSB, `[7]`) to 8 (LSB, `[0]`). The generated V5 carries BIP-2 bit 1 in `[7]` and bit 2 in `[6]`. Bit 1 is the XOR of bits `[7],[5],[3],[1]` of every output byte from the previous V5 slot (that V5 included) up to the byte before the current V5, with pointer bytes excluded. Bit 2 is the same over bits `[6],[4],[2],[0]`.
- R6: A V5 generated in state S_SEEK, before any earlier V5 since reset, carries 00 in its BIP-2 field, apart from error injection.
- R7: The label field `[3:1]` is 000 (unequipped) for mapping type 0. It equals the type value for types 1 to 7, and is 001 for types 8 to 15.
- R8: In UPSR mode (`upsr_en` high, `lb_en` and `ais_en` low), bits `[5]` (REI-V), `[4]` (RFI-V) and `[0]` (RDI-V) are copied from `rx_v5`. In plain generation mode these bits are 0.
- R9: Error mode 01 inverts both BIP-2 bits of every generated V5. Modes 00 and 11 leave them intact.
- R10: In error mode 10, a pulse on `err_shot` arms a single corruption. The next generated V5 slot after the pulse inverts both BIP-2 bits, and the following V5 slot does not. A pulse in the same cycle as a V5 slot arms the following V5 slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input byte valid |
| in_byte | input | 8 | Tributary byte in |
| in_ptr | input | 1 | Byte is a pointer byte (V1 to V4) |
| in_v5 | input | 1 | Byte slot is V5 |
| map_type | input | 4 | Mapping type selecting the signal label |
| lb_en | input | 1 | Tributary loopback |
| upsr_en | input | 1 | UPSR partial regeneration |
| ais_en | input | 1 | AIS-V insertion |
| err_mode | input | 2 | BIP-2 error injection mode |
| err_shot | input | 1 | Single-shot error strobe |
| rx_v5 | input | 8 | Stored received V5 byte |
| out_vld | output | 1 | Output byte valid |
| out_byte | output | 8 | Tributary byte out |

## Verification
Every output byte appears one edge after its input byte is taken. The bench therefore pairs outputs with expectations in strict order: the driver queues the expected byte as it drives, and the monitor pops one entry on each falling edge where `out_vld` is high. The parity in a V5 depends on the whole preceding superframe. The bench model therefore accumulates parity over the expected output bytes and excludes pointer bytes. A single-shot strobe takes effect at the V5 slot after it, which lies several bytes later, so the model holds its own armed flag across those cycles.

// File: rtl/v5gen_pkg.sv
package v5gen_pkg;
    localparam int BYTE_W  = 8;
    localparam int MAP_W   = 4;
    localparam int LABEL_W = 3;
    localparam int BIP_W   = 2;

    typedef enum logic [0:0] {
        S_SEEK = 1'b0,
        S_RUN  = 1'b1
    } v5_state_e;

    typedef enum logic [1:0] {
        ERR_OFF  = 2'b00,
        ERR_CONT = 2'b01,
        ERR_SHOT = 2'b10,
        ERR_NONE = 2'b11
    } err_mode_e;

    typedef struct packed {
        logic [BIP_W-1:0]   bip;
        logic               rei;
        logic               rfi;
        logic [LABEL_W-1:0] sig_lbl;
        logic               rdi;
    } v5_fields_t;
endpackage

// File: rtl/v5_bip_acc.sv
module v5_bip_acc
    import v5gen_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [W-1:0]     data,
    output logic [BIP_W-1:0] acc
);
    logic [BIP_W-1:0] byte_par;

    always_comb begin
        byte_par = '0;
        for (int i = 0; i < W; i++) begin
            if (((W - i) % 2) == 1) byte_par[1] = byte_par[1] ^ data[i];
            else                    byte_par[0] = byte_par[0] ^ data[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  acc <= '0;
        else if (en) acc <= (restart ? '0 : acc) ^ byte_par;
    end
endmodule

// File: rtl/v5_label_map.sv
module v5_label_map
    import v5gen_pkg::*;
(
    input  logic [MAP_W-1:0]   map_type,
    output logic [LABEL_W-1:0] sig_lbl
);
    localparam logic [LABEL_W-1:0] LBL_UNEQ    = '0;
    localparam logic [LABEL_W-1:0] LBL_GENERIC = LABEL_W'(1);

    always_comb begin
        if (map_type == '0)
            sig_lbl = LBL_UNEQ;
        else if (map_type[MAP_W-1:LABEL_W] == '0)
            sig_lbl = map_type[LABEL_W-1:0];
        else
            sig_lbl = LBL_GENERIC;
    end
endmodule

// File: rtl/v5_err_ctl.sv
module v5_err_ctl
    import v5gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shot,
    input  logic       slot,
    input  logic [1:0] mode,
    output logic       corrupt
);
    logic pend;

    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (slot) pend <= shot;
        else if (shot) pend <= 1'b1;
    end

    always_comb begin
        unique case (err_mode_e'(mode))
            ERR_CONT: corrupt = 1'b1;
            ERR_SHOT: corrupt = pend;
            ERR_OFF,
            ERR_NONE: corrupt = 1'b0;
            default:  corrupt = 1'b0;
        endcase
    end

    // R10: a pending shot in mode 10 must corrupt and then be consumed
    p_shot_consumed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && !shot) |=> !pend);
endmodule

// File: rtl/v5_overhead_gen.sv
module v5_overhead_gen
    import v5gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_ptr,
    input  logic              in_v5,
    input  logic [MAP_W-1:0]  map_type,
    input  logic              lb_en,
    input  logic              upsr_en,
    input  logic              ais_en,
    input  logic [1:0]        err_mode,
    input  logic              err_shot,
    input  logic [BYTE_W-1:0] rx_v5,
    output logic              out_vld,
    output logic [BYTE_W-1:0] out_byte
);
    v5_state_e          state, state_nxt;
    logic [BIP_W-1:0]   acc;
    logic [LABEL_W-1:0] sig_lbl;
    logic               corrupt;
    logic               v5_slot;
    v5_fields_t         rx_f, gen_f;
    logic [BYTE_W-1:0]  sel_byte;

    assign v5_slot = in_vld && in_v5;
    assign rx_f    = v5_fields_t'(rx_v5);

    v5_label_map u_label (
        .map_type (map_type),
        .sig_lbl  (sig_lbl)
    );

    v5_err_ctl u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .shot    (err_shot),
        .slot    (v5_slot),
        .mode    (err_mode),
        .corrupt (corrupt)
    );

    v5_bip_acc #(.W(BYTE_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (in_vld && !in_ptr),
        .restart (in_v5),
        .data    (sel_byte),
        .acc     (acc)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_SEEK;
        else        state <= state_nxt;
    end

    // Transitions: T_FIRST_V5 (S_SEEK -> S_RUN), T_HOLD otherwise
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_SEEK:  if (v5_slot) state_nxt = S_RUN;
            S_RUN:   state_nxt = S_RUN;
            default: state_nxt = S_SEEK;
        endcase
    end

    // V5 field assembly and byte selection
    always_comb begin
        gen_f.bip     = ((state == S_RUN) ? acc : '0) ^ {BIP_W{corrupt}};
        gen_f.sig_lbl = sig_lbl;
        gen_f.rei     = upsr_en ? rx_f.rei : 1'b0;
        gen_f.rfi     = upsr_en ? rx_f.rfi : 1'b0;
        gen_f.rdi     = upsr_en ? rx_f.rdi : 1'b0;
        if (ais_en)      sel_byte = '1;
        else if (!in_v5) sel_byte = in_byte;
        else if (lb_en)  sel_byte = rx_v5;
        else             sel_byte = BYTE_W'(gen_f);
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_byte <= '0;
        end else begin
            out_vld  <= in_vld;
            if (in_vld) out_byte <= sel_byte;
        end
    end

    p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    p_vld_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    p_pass_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_v5 && !ais_en) |=> (out_byte == $past(in_byte)));
    p_ais_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && ais_en) |=> (out_byte == '1));
    p_loop_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (v5_slot && lb_en && !ais_en) |=> (out_byte == $past(rx_v5)));
    p_seek_bip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (v5_slot && state == S_SEEK && !lb_en && !ais_en && !err_mode[0] && !err_mode[1])
        |=> (out_byte[7:6] == 2'b00));
    p_uneq_label_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (v5_slot && !lb_en && !ais_en && map_type == '0) |=> (out_byte[3:1] == 3'b000));
    p_upsr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (v5_slot && upsr_en && !lb_en && !ais_en)
        |=> (out_byte[5:4] == $past(rx_v5[5:4]) && out_byte[0] == $past(rx_v5[0])));
    p_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN) |=> (state == S_RUN));
endmodule

// File: tb/v5_overhead_gen_tb.sv
module v5_overhead_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_ptr = 1'b0;
    logic       in_v5 = 1'b0;
    logic [3:0] map_type = 4'd4;
    logic       lb_en = 1'b0;
    logic       upsr_en = 1'b0;
    logic       ais_en = 1'b0;
    logic [1:0] err_mode = 2'b00;
    logic       err_shot = 1'b0;
    logic [7:0] rx_v5 = '0;
    logic       out_vld;
    logic [7:0] out_byte;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] q_val[$];
    string      q_req[$];

    logic [1:0] m_acc = '0;
    bit         m_seek = 1'b1;
    bit         m_pend = 1'b0;

    always #5 clk = ~clk;

    v5_overhead_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
        .in_ptr(in_ptr), .in_v5(in_v5), .map_type(map_type), .lb_en(lb_en),
        .upsr_en(upsr_en), .ais_en(ais_en), .err_mode(err_mode),
        .err_shot(err_shot), .rx_v5(rx_v5), .out_vld(out_vld), .out_byte(out_byte)
    );

    function automatic logic [1:0] par2(input logic [7:0] b);
        return {b[7] ^ b[5] ^ b[3] ^ b[1], b[6] ^ b[4] ^ b[2] ^ b[0]};
    endfunction

    function automatic logic [2:0] lbl_of(input logic [3:0] t);
        if (t == 4'd0)     return 3'b000;
        else if (t < 4'd8) return t[2:0];
        else               return 3'b001;
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input bit ptr, input bit v5, input bit shot, input string req);
        logic [7:0] e;
        logic [1:0] bip;
        bit cor;
        @(negedge clk);
        in_vld = 1'b1; in_byte = b; in_ptr = ptr; in_v5 = v5; err_shot = shot;
        if (ais_en)      e = 8'hFF;
        else if (!v5)    e = b;
        else if (lb_en)  e = rx_v5;
        else begin
            cor = (err_mode == 2'b01) || (err_mode == 2'b10 && m_pend);
            bip = (m_seek ? 2'b00 : m_acc) ^ {2{cor}};
            e = {bip, upsr_en & rx_v5[5], upsr_en & rx_v5[4], lbl_of(map_type), upsr_en & rx_v5[0]};
        end
        if (v5) begin
            m_seek = 1'b0;
            m_pend = shot;
        end else if (shot) begin
            m_pend = 1'b1;
        end
        if (!ptr) m_acc = (v5 ? 2'b00 : m_acc) ^ par2(e);
        q_val.push_back(e);
        q_req.push_back(req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0; in_v5 = 1'b0; in_ptr = 1'b0; err_shot = 1'b0;
        end
    endtask

    // one superframe: a pointer byte, the V5 slot, then n payload bytes
    task automatic sframe(input int n, input int seed, input string v5req,
                          input bit shot_v5, input bit shot_data);
        send(8'(seed * 13 + 7), 1'b1, 1'b0, 1'b0, ais_en ? "R3" : "R2");
        send(8'(seed), 1'b0, 1'b1, shot_v5, ais_en ? "R3" : v5req);
        for (int i = 0; i < n; i++)
            send(8'(seed * 29 + i * 71 + 3), 1'b0, 1'b0, shot_data && (i == 1),
                 ais_en ? "R3" : "R2");
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (q_val.size() == 0) begin
                check(1'b0, "R1 unexpected output", out_byte, 8'h00);
            end else begin
                logic [7:0] ev;
                string      er;
                ev = q_val.pop_front();
                er = q_req.pop_front();
                check(out_byte === ev, er, out_byte, ev);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_vld === 1'b0 && out_byte === 8'h00, "R1 reset", out_byte, 8'h00);
        rst_n = 1'b1;
        idle(2);

        // plain generation, first V5 in S_SEEK
        map_type = 4'd4;
        sframe(10, 1, "R6", 1'b0, 1'b0);
        sframe(10, 2, "R5", 1'b0, 1'b0);
        sframe(7, 3, "R5", 1'b0, 1'b0);
        idle(1); map_type = 4'd0;
        sframe(9, 4, "R7", 1'b0, 1'b0);
        idle(1); map_type = 4'd11;
        sframe(9, 5, "R7", 1'b0, 1'b0);
        idle(1); map_type = 4'd2; upsr_en = 1'b1; rx_v5 = 8'b0010_1101;
        sframe(8, 6, "R8", 1'b0, 1'b0);
        idle(1); rx_v5 = 8'b1101_0010;
        sframe(8, 7, "R8", 1'b0, 1'b0);
        idle(1); upsr_en = 1'b0; err_mode = 2'b01;
        sframe(8, 8, "R9", 1'b0, 1'b0);
        sframe(8, 9, "R9", 1'b0, 1'b0);
        idle(1); err_mode = 2'b11;
        sframe(8, 10, "R9", 1'b0, 1'b0);
        idle(1); err_mode = 2'b10;
        sframe(8, 11, "R10", 1'b0, 1'b1);
        sframe(8, 12, "R10", 1'b0, 1'b0);
        sframe(8, 13, "R10", 1'b1, 1'b0);
        sframe(8, 14, "R10", 1'b0, 1'b0);
        idle(1); lb_en = 1'b1; err_mode = 2'b01; rx_v5 = 8'h5A;
        sframe(6, 15, "R4", 1'b0, 1'b0);
        idle(1); ais_en = 1'b1;
        sframe(6, 16, "R3", 1'b0, 1'b0);
        idle(1); ais_en = 1'b0; lb_en = 1'b0; err_mode = 2'b00; map_type = 4'd7;
        sframe(6, 17, "R5", 1'b0, 1'b0);
        sframe(5, 18, "R5", 1'b0, 1'b0);
        idle(3);
        check(out_vld === 1'b0, "R1 idle", {7'd0, out_vld}, 8'h00);
        check(q_val.size() == 0, "R1 drained", 8'(q_val.size()), 8'h00);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule